// File: doc/BRIEF.md
# Negacyclic Number Theoretic Transform Engine

This block transforms a polynomial of degree below `N` with coefficients modulo a prime `Q`, working in the ring of polynomials reduced modulo x^N + 1. It can run the forward transform, which evaluates the polynomial at the odd powers of a primitive 2N-th root of unity `PSI`. It can also run the inverse transform, which rebuilds the coefficients from those evaluations. Both transforms work in place on an internal coefficient store of `N` words. One modular butterfly serves every stage.

The host loads coefficients through a plain write port while the engine is idle. It then pulses `start` with `inverse` set to choose the direction and waits for the single-cycle `done` pulse. After that it reads the results through the same address port. The forward transform uses decimation-in-time butterflies with twiddles in bit-reversed order, so its results come out in bit-reversed order. The inverse transform uses decimation-in-frequency butterflies and takes that order back. It then makes one extra pass that multiplies every coefficient by N^-1 mod Q. Each modular product goes through a Montgomery reducer. The twiddles are stored already scaled by the Montgomery radix, and the twiddle tables are computed when the design is elaborated.

The defaults are N = 256, Q = 12289 (Q ≡ 1 mod 2N, 14-bit words) and PSI = 2401, which is a primitive 512th root of unity mod 12289. If `N` or `Q` is changed, `PSI` must be changed with it.

Top module: `negacyclic_ntt`

## Requirements
- R1: After a forward run, the word at address j is the sum over i of a_i·PSI^((2·rev(j)+1)·i) mod Q. Here a_i is the coefficient loaded at address i, and rev(j) reverses the log2(N) bits of j. PSI satisfies PSI^N ≡ Q−1.
- R2: An inverse run applied to the output of a forward run returns the original coefficients. A forward run applied to the output of an inverse run also returns its input. The inverse includes the scaling by N^-1 mod Q.
- R3: When host inputs are below Q, every word the engine writes back is in the range [0, Q).
- R4: `done` is asserted exactly N·log2(N) clock edges after the edge that accepts `start` with `inverse`=0. With `inverse`=1 the count is N·(log2(N)+1). The count does not depend on the coefficient values.
- R5: `busy` is high from the cycle after `start` is accepted until the last write-back. In the `done` cycle `busy` is low, and `done` is high for exactly one cycle.
- R6: While `busy` is high, `host_we` writes are ignored and so is a new `start`. The result and the run length stay the same.
- R7: After a synchronous active-low reset, `busy` and `done` are both 0.
- R8: While idle, `host_we`=1 writes `host_wdata` to `host_addr` on the clock edge. `host_rdata` shows the word at the `host_addr` sampled on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transform; accepted only while idle |
| inverse | input | 1 | 0 selects forward, 1 selects inverse; sampled with `start` |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| host_we | input | 1 | Coefficient write enable (ignored while busy) |
| host_addr | input | log2(N) | Coefficient address |
| host_wdata | input | W | Coefficient to write, must be below Q |
| host_rdata | output | W | Coefficient read, one cycle after its address |

## Verification
A host read is due one edge after its address is applied, so the bench sets the address at a falling edge and samples just after the next rising edge. Counting from the rising edge that accepts `start`, `done` is due N·log2(N) edges later for a forward run and N·(log2(N)+1) edges later for an inverse run. The bench counts rising edges and looks at `busy` and `done` at each falling edge. It requires `busy` in every earlier count, `done` exactly at the expected count, and `done` gone one edge later. Forward results are compared with a direct evaluation at the odd powers of PSI. Inverse results are compared with the original polynomial.

// File: rtl/ntt_pkg.sv
// Shared types and elaboration-time arithmetic for the NTT engine.
// Assumes all moduli fit in 32 bits so that products fit in 64 bits.
package ntt_pkg;

    typedef enum logic [1:0] {
        OP_CT    = 2'd0,   // forward decimation-in-time butterfly
        OP_GS    = 2'd1,   // inverse decimation-in-frequency butterfly
        OP_SCALE = 2'd2    // multiply both words by N^-1
    } bf_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WB   = 2'd2
    } ctrl_state_e;

    // b^e mod q by square and multiply
    function automatic longint unsigned np_modpow(longint unsigned b, longint unsigned e,
                                                  longint unsigned q);
        longint unsigned r;
        longint unsigned bb;
        r  = 1;
        bb = b % q;
        for (int k = 0; k < 32; k++) begin
            if (((e >> k) & 64'd1) == 64'd1) r = (r * bb) % q;
            bb = (bb * bb) % q;
        end
        return r;
    endfunction

    // reverse the low 'bits' bits of v
    function automatic longint unsigned np_bitrev(longint unsigned v, int bits);
        longint unsigned r;
        r = 0;
        for (int k = 0; k < 32; k++) begin
            if (k < bits) r = r | (((v >> k) & 64'd1) << (bits - 1 - k));
        end
        return r;
    endfunction

    // -q^-1 mod 2^rw, Newton iteration on an odd q
    function automatic longint unsigned np_qinv_neg(longint unsigned q, int rw);
        longint unsigned inv;
        longint unsigned mask;
        inv = q;
        for (int k = 0; k < 6; k++) inv = inv * (64'd2 - q * inv);
        mask = (64'd1 << rw) - 64'd1;
        return (64'd0 - inv) & mask;
    endfunction

    // x * 2^rw mod q
    function automatic longint unsigned np_to_mont(longint unsigned x, longint unsigned q, int rw);
        return (x << rw) % q;
    endfunction

endpackage

// File: rtl/ntt_twiddle_rom.sv
// Twiddle store: forward powers PSI^rev(k), inverse powers PSI^-rev(k) and
// the N^-1 scale factor, all in Montgomery form (times 2^W mod Q).
// Assumes PSI is a primitive 2N-th root of unity modulo the prime Q.
module ntt_twiddle_rom
    import ntt_pkg::*;
#(
    parameter int N   = 256,
    parameter int Q   = 12289,
    parameter int W   = 14,
    parameter int PSI = 2401,
    localparam int LOGN = $clog2(N)
) (
    input  logic [LOGN-1:0] idx,
    input  bf_op_e          op,
    output logic [W-1:0]    tw
);

    localparam longint unsigned SCALE_M =
        np_to_mont(np_modpow(64'(N), 64'(Q - 2), 64'(Q)), 64'(Q), W);

    logic [W-1:0] fwd_tab [N];
    logic [W-1:0] inv_tab [N];

    for (genvar k = 0; k < N; k++) begin : g_tab
        localparam longint unsigned EXP = np_bitrev(64'(k), LOGN);
        localparam longint unsigned FV  =
            np_to_mont(np_modpow(64'(PSI), EXP, 64'(Q)), 64'(Q), W);
        localparam longint unsigned IV  =
            np_to_mont(np_modpow(64'(PSI), 64'(2 * N) - EXP, 64'(Q)), 64'(Q), W);
        assign fwd_tab[k] = FV[W-1:0];
        assign inv_tab[k] = IV[W-1:0];
    end

    // pick the table for the current butterfly kind
    always_comb begin
        case (op)
            OP_CT:   tw = fwd_tab[idx];
            OP_GS:   tw = inv_tab[idx];
            default: tw = SCALE_M[W-1:0];
        endcase
    end

endmodule

// File: rtl/ntt_mont_mul.sv
// Combinational Montgomery product p = a*b*2^-W mod Q, fully reduced.
// Assumes a, b < Q < 2^W and Q odd; constant logic depth for all inputs.
module ntt_mont_mul
    import ntt_pkg::*;
#(
    parameter int Q = 12289,
    parameter int W = 14
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);

    localparam longint unsigned QINV_L = np_qinv_neg(64'(Q), W);
    localparam logic [W-1:0]    QINV   = QINV_L[W-1:0];
    localparam logic [2*W:0]    QWIDE  = (2*W+1)'(Q);
    localparam logic [W:0]      QV     = (W+1)'(Q);

    logic [2*W-1:0] t_full;
    logic [2*W-1:0] m_full;
    logic [W-1:0]   m;
    logic [2*W:0]   s;
    logic [W:0]     r;
    logic [W:0]     r_sub;

    // reduce the product by the Montgomery radix
    always_comb begin
        t_full = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        m_full = {{W{1'b0}}, t_full[W-1:0]} * {{W{1'b0}}, QINV};
        m      = m_full[W-1:0];
        s      = {1'b0, t_full} + ({{(W+1){1'b0}}, m} * QWIDE);
        r      = s[2*W:W];
        r_sub  = r - QV;
        p      = (r >= QV) ? r_sub[W-1:0] : r[W-1:0];
    end

endmodule

// File: rtl/ntt_butterfly.sv
// Modular butterfly for the three pass kinds:
//   OP_CT    : x = u + w*v,  y = u - w*v
//   OP_GS    : x = u + v,    y = (u - v)*w
//   OP_SCALE : x = u*w,      y = v*w
// tw holds w in Montgomery form; inputs below Q give outputs below Q.
module ntt_butterfly
    import ntt_pkg::*;
#(
    parameter int Q = 12289,
    parameter int W = 14
) (
    input  bf_op_e       op,
    input  logic [W-1:0] u,
    input  logic [W-1:0] v,
    input  logic [W-1:0] tw,
    output logic [W-1:0] x,
    output logic [W-1:0] y
);

    localparam logic [W:0] QV = (W+1)'(Q);

    function automatic logic [W-1:0] f_addq(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= QV) s = s - QV;
        return s[W-1:0];
    endfunction

    function automatic logic [W-1:0] f_subq(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] d;
        if (a >= b) d = {1'b0, a} - {1'b0, b};
        else        d = {1'b0, a} + QV - {1'b0, b};
        return d[W-1:0];
    endfunction

    logic [W-1:0] diff_gs;
    logic [W-1:0] mul0_in;
    logic [W-1:0] prod0;
    logic [W-1:0] prod1;

    // operand for the shared multiplier
    always_comb begin
        diff_gs = f_subq(u, v);
        mul0_in = (op == OP_GS) ? diff_gs : v;
    end

    ntt_mont_mul #(.Q(Q), .W(W)) mul0_i (.a(mul0_in), .b(tw), .p(prod0));
    ntt_mont_mul #(.Q(Q), .W(W)) mul1_i (.a(u),       .b(tw), .p(prod1));

    // combine products into the two results
    always_comb begin
        case (op)
            OP_CT: begin
                x = f_addq(u, prod0);
                y = f_subq(u, prod0);
            end
            OP_GS: begin
                x = f_addq(u, v);
                y = prod0;
            end
            default: begin
                x = prod1;
                y = prod0;
            end
        endcase
    end

endmodule

// File: rtl/ntt_ctrl.sv
// Sequencer: walks stages and butterfly pairs, two cycles per pair
// (read, then write back). The forward run has log2(N) stages. The inverse
// run has log2(N) stages plus one scaling pass. start is taken only when idle.
module ntt_ctrl
    import ntt_pkg::*;
#(
    parameter int N = 256,
    localparam int LOGN = $clog2(N),
    localparam int SW   = $clog2(LOGN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            inverse,
    output logic            busy,
    output logic            done,
    output logic            eng_we,
    output logic [LOGN-1:0] addr_lo,
    output logic [LOGN-1:0] addr_hi,
    output logic [LOGN-1:0] tw_idx,
    output bf_op_e          op
);

    localparam logic [LOGN-2:0] PAIR_LAST = '1;
    localparam logic [SW-1:0]   ST_SCALE  = SW'(LOGN);
    localparam logic [SW-1:0]   ST_FLAST  = SW'(LOGN - 1);

    ctrl_state_e     state;
    logic            mode_inv;
    logic [SW-1:0]   stage;
    logic [LOGN-2:0] pair;
    logic            last_stage;

    int              g;
    logic [LOGN-1:0] pext;
    logic [LOGN-1:0] grp;
    logic [LOGN-1:0] offm;
    logic [LOGN-1:0] lo_c;

    // pass kind and stage bookkeeping
    always_comb begin
        last_stage = mode_inv ? (stage == ST_SCALE) : (stage == ST_FLAST);
        if (!mode_inv)              op = OP_CT;
        else if (stage == ST_SCALE) op = OP_SCALE;
        else                        op = OP_GS;
    end

    // pair index to the two word addresses and the twiddle index
    always_comb begin
        g    = mode_inv ? int'(stage) : (LOGN - 1 - int'(stage));
        pext = {1'b0, pair};
        grp  = pext >> g;
        offm = (LOGN'(1) << g) - LOGN'(1);
        lo_c = (grp << (g + 1)) | (pext & offm);
        if (op == OP_SCALE) begin
            addr_lo = {pair, 1'b0};
            addr_hi = {pair, 1'b1};
            tw_idx  = '0;
        end else begin
            addr_lo = lo_c;
            addr_hi = lo_c | (LOGN'(1) << g);
            tw_idx  = (LOGN'(1) << (LOGN - 1 - g)) | grp;
        end
    end

    assign busy   = (state != ST_IDLE);
    assign eng_we = (state == ST_WB);

    // state machine over pairs and stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mode_inv <= 1'b0;
            stage    <= '0;
            pair     <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_inv <= inverse;
                        stage    <= '0;
                        pair     <= '0;
                        state    <= ST_RD;
                    end
                end
                ST_RD: state <= ST_WB;
                ST_WB: begin
                    state <= ST_RD;
                    if (pair == PAIR_LAST) begin
                        pair <= '0;
                        if (last_stage) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            stage <= stage + SW'(1);
                        end
                    end else begin
                        pair <= pair + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/negacyclic_ntt.sv
// Negacyclic NTT engine top: coefficient store with two synchronous ports,
// sequencer, twiddle store and one butterfly. The host owns port A while
// idle. While busy the engine owns both ports and host writes are dropped.
module negacyclic_ntt
    import ntt_pkg::*;
#(
    parameter int N   = 256,
    parameter int Q   = 12289,
    parameter int W   = 14,
    parameter int PSI = 2401,
    localparam int LOGN = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            inverse,
    output logic            busy,
    output logic            done,
    input  logic            host_we,
    input  logic [LOGN-1:0] host_addr,
    input  logic [W-1:0]    host_wdata,
    output logic [W-1:0]    host_rdata
);

    logic            eng_we;
    logic [LOGN-1:0] eng_lo;
    logic [LOGN-1:0] eng_hi;
    logic [LOGN-1:0] tw_idx;
    bf_op_e          op;
    logic [W-1:0]    tw;
    logic [W-1:0]    bf_x;
    logic [W-1:0]    bf_y;

    logic            we_a;
    logic [LOGN-1:0] addr_a;
    logic [W-1:0]    wd_a;
    logic [W-1:0]    rd_a;
    logic [W-1:0]    rd_b;
    logic [W-1:0]    mem [N];

    ntt_ctrl #(.N(N)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .inverse (inverse),
        .busy    (busy),
        .done    (done),
        .eng_we  (eng_we),
        .addr_lo (eng_lo),
        .addr_hi (eng_hi),
        .tw_idx  (tw_idx),
        .op      (op)
    );

    ntt_twiddle_rom #(.N(N), .Q(Q), .W(W), .PSI(PSI)) rom_i (
        .idx (tw_idx),
        .op  (op),
        .tw  (tw)
    );

    ntt_butterfly #(.Q(Q), .W(W)) bf_i (
        .op (op),
        .u  (rd_a),
        .v  (rd_b),
        .tw (tw),
        .x  (bf_x),
        .y  (bf_y)
    );

    // port A belongs to the host only while idle
    always_comb begin
        if (busy) begin
            we_a   = eng_we;
            addr_a = eng_lo;
            wd_a   = bf_x;
        end else begin
            we_a   = host_we;
            addr_a = host_addr;
            wd_a   = host_wdata;
        end
    end

    // coefficient store, two synchronous read/write ports
    always_ff @(posedge clk) begin
        if (we_a)   mem[addr_a] <= wd_a;
        if (eng_we) mem[eng_hi] <= bf_y;
        rd_a <= mem[addr_a];
        rd_b <= mem[eng_hi];
    end

    assign host_rdata = rd_a;

endmodule

// File: rtl/negacyclic_ntt_checker.sv
// Protocol and arithmetic-range properties for negacyclic_ntt, bound below.
// Run length is checked with a counter rather than a long $past window.
module negacyclic_ntt_checker #(
    parameter int N = 256,
    parameter int Q = 12289,
    parameter int W = 14,
    localparam int LOGN = $clog2(N)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            inverse,
    input logic            busy,
    input logic            done,
    input logic            eng_we,
    input logic [W-1:0]    wr_x,
    input logic [W-1:0]    wr_y,
    input logic [LOGN-1:0] addr_lo,
    input logic [LOGN-1:0] addr_hi
);

    localparam int LAT_FWD = LOGN * N;
    localparam int LAT_INV = (LOGN + 1) * N;

    int   run_len;
    logic run_inv;

    // count busy cycles since the accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= 0;
            run_inv <= 1'b0;
        end else if (start && !busy) begin
            run_len <= 0;
            run_inv <= inverse;
        end else if (busy) begin
            run_len <= run_len + 1;
        end
    end

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> (busy || done));

    a_r3_wr_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> ((int'(wr_x) < Q) && (int'(wr_y) < Q)));

    a_r1_pair_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> (addr_lo != addr_hi));

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == (run_inv ? LAT_INV : LAT_FWD)));

endmodule

bind negacyclic_ntt negacyclic_ntt_checker #(.N(N), .Q(Q), .W(W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .inverse (inverse),
    .busy    (busy),
    .done    (done),
    .eng_we  (eng_we),
    .wr_x    (bf_x),
    .wr_y    (bf_y),
    .addr_lo (eng_lo),
    .addr_hi (eng_hi)
);

// File: tb/negacyclic_ntt_tb_top.sv
// Bench: forward results against direct evaluation at odd powers of PSI,
// round trips in both orders, exact run lengths and host-port behaviour.
module negacyclic_ntt_tb_top;

    localparam int N    = 256;
    localparam int Q    = 12289;
    localparam int W    = 14;
    localparam int PSI  = 2401;
    localparam int LOGN = $clog2(N);
    localparam int LAT_FWD = LOGN * N;
    localparam int LAT_INV = (LOGN + 1) * N;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            inverse = 1'b0;
    logic            busy;
    logic            done;
    logic            host_we = 1'b0;
    logic [LOGN-1:0] host_addr = '0;
    logic [W-1:0]    host_wdata = '0;
    logic [W-1:0]    host_rdata;

    int nchk  = 0;
    int nfail = 0;

    int vin  [N];
    int vout [N];
    int vref [N];
    int pw   [2*N];

    always #4 clk = ~clk;

    negacyclic_ntt #(.N(N), .Q(Q), .W(W), .PSI(PSI)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .inverse    (inverse),
        .busy       (busy),
        .done       (done),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int brv(input int v);
        int r = 0;
        for (int k = 0; k < LOGN; k++) if (((v >> k) & 1) == 1) r = r | (1 << (LOGN - 1 - k));
        return r;
    endfunction

    task automatic load_vec();
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            host_we    = 1'b1;
            host_addr  = LOGN'(k);
            host_wdata = W'(vin[k]);
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic read_vec();
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            host_addr = LOGN'(k);
            @(posedge clk);
            #1 vout[k] = int'(host_rdata);
        end
    endtask

    // run one transform; disturb=1 pokes host write and start while busy
    task automatic run(input bit inv, input bit disturb);
        int  cycles = 0;
        bit  busy_ok = 1'b1;
        int  lat = inv ? LAT_INV : LAT_FWD;
        @(negedge clk);
        start   = 1'b1;
        inverse = inv;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (!done && cycles < lat + 50) begin
            if (!busy) busy_ok = 1'b0;
            if (disturb && cycles == 7) begin
                host_we = 1'b1; host_addr = LOGN'(3); host_wdata = W'(5);
                start = 1'b1; inverse = ~inv;
            end
            if (disturb && cycles == 9) begin
                host_we = 1'b0; start = 1'b0; inverse = inv;
            end
            @(posedge clk);
            cycles++;
            @(negedge clk);
        end
        chk(cycles == lat, "R4", "run length", cycles, lat);
        chk(busy_ok, "R5", "busy held through run", busy_ok, 1);
        chk(busy == 1'b0, "R5", "busy low with done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R5", "done single cycle", done, 0);
    endtask

    task automatic forward_ref();
        for (int j = 0; j < N; j++) begin
            longint acc = 0;
            int     eb  = 2 * brv(j) + 1;
            for (int i = 0; i < N; i++)
                acc = (acc + longint'(vin[i]) * pw[(eb * i) % (2 * N)]) % Q;
            vref[j] = int'(acc);
        end
    endtask

    task automatic make_pattern(input int p);
        int unsigned s = 32'h1234_5678 + 32'(p);
        for (int i = 0; i < N; i++) begin
            s = s * 1103515245 + 12345;
            case (p)
                0: vin[i] = (i == 0) ? 1 : 0;
                1: vin[i] = (i == 1) ? 1 : 0;
                2: vin[i] = (i == N - 1) ? Q - 1 : 0;
                3: vin[i] = Q - 1;
                4: vin[i] = (i * 37 + 5) % Q;
                default: vin[i] = int'((s >> 8) % Q);
            endcase
        end
    endtask

    // watchdog: an expired run is a failure and still prints the summary
    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        // powers of PSI for the reference
        pw[0] = 1;
        for (int k = 1; k < 2 * N; k++) pw[k] = int'((longint'(pw[k-1]) * PSI) % Q);
        chk(pw[N] == Q - 1, "R1", "PSI^N is -1", pw[N], Q - 1);

        // R7: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R7", "busy in reset", busy, 0);
        chk(done == 1'b0, "R7", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R7", "busy after reset", busy, 0);
        chk(done == 1'b0, "R7", "done after reset", done, 0);

        // R8: host load and readback
        make_pattern(6);
        load_vec();
        read_vec();
        for (int k = 0; k < N; k++)
            chk(vout[k] == vin[k], "R8", $sformatf("readback[%0d]", k), vout[k], vin[k]);

        // R1, R2, R3: forward against reference, then inverse round trip
        for (int p = 0; p < 6; p++) begin
            make_pattern(p);
            forward_ref();
            load_vec();
            run(1'b0, p == 4);   // p==4 also exercises R6
            read_vec();
            for (int k = 0; k < N; k++) begin
                chk(vout[k] == vref[k], (p == 4) ? "R6" : "R1",
                    $sformatf("pattern %0d fwd[%0d]", p, k), vout[k], vref[k]);
                chk(vout[k] < Q, "R3", $sformatf("pattern %0d range[%0d]", p, k), vout[k], Q - 1);
            end
            run(1'b1, 1'b0);
            read_vec();
            for (int k = 0; k < N; k++)
                chk(vout[k] == vin[k], "R2", $sformatf("pattern %0d round trip[%0d]", p, k),
                    vout[k], vin[k]);
        end

        // R2: inverse first, then forward, returns the input
        make_pattern(9);
        load_vec();
        run(1'b1, 1'b1);
        read_vec();
        for (int k = 0; k < N; k++)
            chk(vout[k] < Q, "R3", $sformatf("inverse range[%0d]", k), vout[k], Q - 1);
        run(1'b0, 1'b0);
        read_vec();
        for (int k = 0; k < N; k++)
            chk(vout[k] == vin[k], "R2", $sformatf("reverse round trip[%0d]", k), vout[k], vin[k]);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule